// File: doc/BRIEF.md
# Virtual Interrupt Aggregator

This block funnels a stream of numbered event pulses into a small, parameterized set of virtual interrupt lines. A writable routing table sends each incoming 16-bit global event number to one virtual interrupt and to one of that line's 64 bit positions. Every bit position carries a status flag and an enable flag. Each virtual interrupt drives one active-high level line to a parent interrupt controller. The line is high while any bit in that virtual interrupt is both pending and enabled.

Software reaches each virtual interrupt through its own 4 KB window on a simple 64-bit register port. At window offsets 0x0 and 0x8 it sets or clears enables by writing ones. At offset 0x18 it reads raw status and acknowledges edge-type bits by writing ones. At offset 0x20 it reads the masked status.

A route can be marked level-type. A bit set by a level-type event ignores software acknowledges and is cleared only by a hardware down event for the same global event number.

Top module: `vint_aggregator`

## Requirements
- R1: After reset, every enable, status and route is cleared, every `irq_out` bit is low and `reg_rdata` reads zero.
- R2: A write to window offset 0x0 sets each enable bit where `reg_wdata` holds a one and leaves the other enable bits unchanged. Reads at offsets 0x0 and 0x8 both return the enable register.
- R3: A write to window offset 0x8 clears each enable bit where `reg_wdata` holds a one and leaves the other enable bits unchanged.
- R4: A read at offset 0x18 returns the raw status. A routed event arrival sets its status bit whether or not that bit is enabled.
- R5: A read at offset 0x20 returns status AND enable. Writes to offset 0x20 change nothing.
- R6: `irq_out[n]` is high exactly when virtual interrupt n has a bit that is both set in status and enabled. The output follows the clock edge that changes the status or enable register.
- R7: Route writes use `map_we` with index `map_idx`. Each route holds a valid flag, a level flag, a target virtual interrupt and a bit position. An event with `ev_down`=0 sets bit `map_bit` of virtual interrupt `map_vint` for its global number. An event is dropped when its route is not valid, when its number is at or above MAP_DEPTH, or when its target has no window. A route write takes effect for events after the write's clock edge. Route writes with an index at or above MAP_DEPTH are ignored.
- R8: Writing ones at offset 0x18 clears those status bits that were set by edge-type events.
- R9: When an arrival and a one-written acknowledge hit the same status bit in the same cycle, the bit stays set.
- R10: A status bit set by a level-type event is not cleared by an acknowledge. An event with `ev_down`=1 clears the routed status bit.
- R11: An access to a window index of NUM_VINT or above, or to any offset other than 0x0, 0x8, 0x18 or 0x20, reads zero and changes no state.
- R12: Read data appears on `reg_rdata` in the cycle after the read request and holds until the next read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_id | input | EVT_W | Global event number |
| ev_down | input | 1 | 1: down event (clears), 0: arrival (sets) |
| map_we | input | 1 | Route table write strobe |
| map_idx | input | EVT_W | Global event number whose route is written |
| map_valid | input | 1 | Route valid flag |
| map_level | input | 1 | Route is level-type |
| map_vint | input | VIDX_W | Target virtual interrupt |
| map_bit | input | 6 | Target bit position |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1: write, 0: read |
| reg_addr | input | ADDR_W | Byte address: window index above bit 11, offset in bits 11:0 |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |
| irq_out | output | NUM_VINT | Level interrupt per virtual interrupt |

## Verification
Directed cases walk a single bit through each path: arrival while masked, enabling, a blocked write to masked status, an acknowledge that collides with an arrival, and an acknowledge on its own. The same is done for a level-type route, which must survive the acknowledge and fall only on its down event. These cases separate the edge and level clear rules and the set-over-clear priority. A random phase mixes route rewrites, unmapped and out-of-range event numbers, down events, and writes and reads to valid, unimplemented and misaligned addresses. After every cycle it compares each interrupt line and the returned read data with a bench model. This exposes crossed windows, wrong offsets, bits leaking between virtual interrupts and stale routing.

// File: rtl/vagg_pkg.sv
package vagg_pkg;
  localparam int unsigned VINT_BITS = 64;
  localparam int unsigned BITPOS_W  = 6;
  localparam int unsigned WOFS_W    = 12;

  localparam logic [WOFS_W-1:0] OFS_EN_SET = 12'h000;
  localparam logic [WOFS_W-1:0] OFS_EN_CLR = 12'h008;
  localparam logic [WOFS_W-1:0] OFS_RAW    = 12'h018;
  localparam logic [WOFS_W-1:0] OFS_MASKED = 12'h020;

  typedef logic [VINT_BITS-1:0] vec_t;

  typedef struct packed {
    logic                valid;
    logic                level;
    logic [BITPOS_W-1:0] bitpos;
  } route_t;
endpackage

// File: rtl/vagg_rst_sync.sv
module vagg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/vagg_evt_map.sv
module vagg_evt_map
  import vagg_pkg::*;
#(
  parameter int unsigned NUM_VINT  = 4,
  parameter int unsigned EVT_W     = 16,
  parameter int unsigned MAP_DEPTH = 64,
  parameter int unsigned VIDX_W    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  map_we,
  input  logic [EVT_W-1:0]      map_idx,
  input  logic                  map_valid,
  input  logic                  map_level,
  input  logic [VIDX_W-1:0]     map_vint,
  input  logic [BITPOS_W-1:0]   map_bit,
  input  logic                  ev_valid,
  input  logic [EVT_W-1:0]      ev_id,
  input  logic                  ev_down,
  output vec_t [NUM_VINT-1:0]   arr_set,
  output vec_t [NUM_VINT-1:0]   arr_lvl,
  output vec_t [NUM_VINT-1:0]   dn_clr
);
  localparam int unsigned MIDX_W = (MAP_DEPTH > 1) ? $clog2(MAP_DEPTH) : 1;

  route_t            rt_q [MAP_DEPTH];
  route_t            rt_d [MAP_DEPTH];
  logic [VIDX_W-1:0] vs_q [MAP_DEPTH];
  logic [VIDX_W-1:0] vs_d [MAP_DEPTH];

  logic              map_hit;
  logic              ev_in_rng;
  route_t            cur_rt;
  logic [VIDX_W-1:0] cur_vs;
  vec_t              cur_mask;

  assign map_hit   = map_we && (32'(map_idx) < MAP_DEPTH);
  assign ev_in_rng = ev_valid && (32'(ev_id) < MAP_DEPTH);

  // next-state of the route table
  always_comb begin
    rt_d = rt_q;
    vs_d = vs_q;
    if (map_hit) begin
      rt_d[map_idx[MIDX_W-1:0]] = route_t'({map_valid, map_level, map_bit});
      vs_d[map_idx[MIDX_W-1:0]] = map_vint;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAP_DEPTH; i++) begin
        rt_q[i] <= '0;
        vs_q[i] <= '0;
      end
    end else if (map_hit) begin
      rt_q <= rt_d;
      vs_q <= vs_d;
    end
  end

  // lookup uses the table contents before any same-cycle write
  always_comb begin
    if (ev_in_rng) begin
      cur_rt = rt_q[ev_id[MIDX_W-1:0]];
      cur_vs = vs_q[ev_id[MIDX_W-1:0]];
    end else begin
      cur_rt = '0;
      cur_vs = '0;
    end
    cur_mask = vec_t'(1) << cur_rt.bitpos;
  end

  for (genvar v = 0; v < NUM_VINT; v++) begin : g_route
    logic tgt;
    assign tgt        = ev_in_rng && cur_rt.valid && (cur_vs == VIDX_W'(v));
    assign arr_set[v] = (tgt && !ev_down) ? cur_mask : '0;
    assign arr_lvl[v] = cur_rt.level ? arr_set[v] : '0;
    assign dn_clr[v]  = (tgt && ev_down) ? cur_mask : '0;
  end
endmodule

// File: rtl/vagg_vint_bank.sv
module vagg_vint_bank
  import vagg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  vec_t en_set,
  input  vec_t en_clr,
  input  vec_t ack,
  input  vec_t arr_set,
  input  vec_t arr_lvl,
  input  vec_t dn_clr,
  output vec_t en_q,
  output vec_t st_q,
  output logic irq
);
  vec_t en_d, st_d, lvl_q, lvl_d;
  vec_t ack_edge, arr_edge;
  logic en_ce, st_ce;

  assign ack_edge = ack & ~lvl_q;
  assign arr_edge = arr_set & ~arr_lvl;

  always_comb begin
    en_ce = (|en_set) || (|en_clr);
    st_ce = (|arr_set) || (|ack) || (|dn_clr);
    en_d  = (en_q | en_set) & ~en_clr;
    st_d  = (st_q & ~ack_edge & ~dn_clr) | arr_set;
    lvl_d = (lvl_q & ~dn_clr & ~arr_edge) | arr_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      lvl_q <= '0;
    end else if (st_ce) begin
      st_q  <= st_d;
      lvl_q <= lvl_d;
    end
  end

  assign irq = |(st_q & en_q);

  // R2
  set_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set != '0) |=> ((en_q & $past(en_set)) == $past(en_set)));

  // R3
  clr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr != '0) |=> ((en_q & $past(en_clr)) == '0));

  // R9
  arrival_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_set != '0) |=> ((st_q & $past(arr_set)) == $past(arr_set)));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack & ~lvl_q & ~arr_set) != '0) |=> ((st_q & $past(ack & ~lvl_q & ~arr_set)) == '0));

  // R10
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack & lvl_q & st_q & ~dn_clr) != '0) |=>
      ((st_q & $past(ack & lvl_q & st_q & ~dn_clr)) == $past(ack & lvl_q & st_q & ~dn_clr)));
endmodule

// File: rtl/vagg_reg_dec.sv
module vagg_reg_dec
  import vagg_pkg::*;
#(
  parameter int unsigned NUM_VINT = 4,
  parameter int unsigned VIDX_W   = 2,
  parameter int unsigned ADDR_W   = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_req,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  vec_t                reg_wdata,
  input  vec_t [NUM_VINT-1:0] en_q,
  input  vec_t [NUM_VINT-1:0] st_q,
  output vec_t [NUM_VINT-1:0] en_set,
  output vec_t [NUM_VINT-1:0] en_clr,
  output vec_t [NUM_VINT-1:0] ack,
  output logic                bad_acc,
  output vec_t                reg_rdata
);
  localparam int unsigned WIN_W = ADDR_W - WOFS_W;

  logic [WIN_W-1:0]  win;
  logic [WOFS_W-1:0] ofs;
  logic              win_ok, ofs_ok, rd_ce;
  logic [VIDX_W-1:0] vidx;
  vec_t              rd_d;

  assign win    = reg_addr[ADDR_W-1:WOFS_W];
  assign ofs    = reg_addr[WOFS_W-1:0];
  assign vidx   = win[VIDX_W-1:0];
  assign win_ok = 32'(win) < NUM_VINT;
  assign ofs_ok = (ofs == OFS_EN_SET) || (ofs == OFS_EN_CLR) ||
                  (ofs == OFS_RAW)    || (ofs == OFS_MASKED);
  assign bad_acc = reg_req && !(win_ok && ofs_ok);
  assign rd_ce   = reg_req && !reg_we;

  for (genvar v = 0; v < NUM_VINT; v++) begin : g_wr
    logic sel;
    assign sel       = reg_req && reg_we && win_ok && (win == WIN_W'(v));
    assign en_set[v] = (sel && ofs == OFS_EN_SET) ? reg_wdata : '0;
    assign en_clr[v] = (sel && ofs == OFS_EN_CLR) ? reg_wdata : '0;
    assign ack[v]    = (sel && ofs == OFS_RAW)    ? reg_wdata : '0;
  end

  always_comb begin
    rd_d = '0;
    if (win_ok) begin
      unique case (ofs)
        OFS_EN_SET, OFS_EN_CLR: rd_d = en_q[vidx];
        OFS_RAW:                rd_d = st_q[vidx];
        OFS_MASKED:             rd_d = st_q[vidx] & en_q[vidx];
        default:                rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (rd_ce) begin
      reg_rdata <= rd_d;
    end
  end
endmodule

// File: rtl/vint_aggregator.sv
module vint_aggregator
  import vagg_pkg::*;
#(
  parameter int unsigned NUM_VINT  = 4,
  parameter int unsigned EVT_W     = 16,
  parameter int unsigned MAP_DEPTH = 64,
  localparam int unsigned VIDX_W   = (NUM_VINT > 1) ? $clog2(NUM_VINT) : 1,
  localparam int unsigned ADDR_W   = VIDX_W + 1 + 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_valid,
  input  logic [EVT_W-1:0]    ev_id,
  input  logic                ev_down,
  input  logic                map_we,
  input  logic [EVT_W-1:0]    map_idx,
  input  logic                map_valid,
  input  logic                map_level,
  input  logic [VIDX_W-1:0]   map_vint,
  input  logic [5:0]          map_bit,
  input  logic                reg_req,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [63:0]         reg_wdata,
  output logic [63:0]         reg_rdata,
  output logic [NUM_VINT-1:0] irq_out
);
  logic                rst_i_n;
  logic                bad_acc;
  vec_t [NUM_VINT-1:0] arr_set, arr_lvl, dn_clr;
  vec_t [NUM_VINT-1:0] en_set, en_clr, ack;
  vec_t [NUM_VINT-1:0] en_all, st_all;

  vagg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  vagg_evt_map #(
    .NUM_VINT  (NUM_VINT),
    .EVT_W     (EVT_W),
    .MAP_DEPTH (MAP_DEPTH),
    .VIDX_W    (VIDX_W)
  ) u_map (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .map_we    (map_we),
    .map_idx   (map_idx),
    .map_valid (map_valid),
    .map_level (map_level),
    .map_vint  (map_vint),
    .map_bit   (map_bit),
    .ev_valid  (ev_valid),
    .ev_id     (ev_id),
    .ev_down   (ev_down),
    .arr_set   (arr_set),
    .arr_lvl   (arr_lvl),
    .dn_clr    (dn_clr)
  );

  vagg_reg_dec #(
    .NUM_VINT (NUM_VINT),
    .VIDX_W   (VIDX_W),
    .ADDR_W   (ADDR_W)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .reg_req   (reg_req),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .en_q      (en_all),
    .st_q      (st_all),
    .en_set    (en_set),
    .en_clr    (en_clr),
    .ack       (ack),
    .bad_acc   (bad_acc),
    .reg_rdata (reg_rdata)
  );

  for (genvar v = 0; v < NUM_VINT; v++) begin : g_bank
    vagg_vint_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .en_set  (en_set[v]),
      .en_clr  (en_clr[v]),
      .ack     (ack[v]),
      .arr_set (arr_set[v]),
      .arr_lvl (arr_lvl[v]),
      .dn_clr  (dn_clr[v]),
      .en_q    (en_all[v]),
      .st_q    (st_all[v]),
      .irq     (irq_out[v])
    );
  end

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(reg_req && !reg_we) |=> $stable(reg_rdata));

  // R11
  bad_wr_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bad_acc && reg_we) |=> $stable(en_all));

  // R5
  masked_ro_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (reg_req && reg_we && reg_addr[11:0] == OFS_MASKED) |=> $stable(en_all));
endmodule

// File: tb/vint_aggregator_tb_top.sv
module vint_aggregator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV   = 4;
  localparam int MD   = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_valid, ev_down, map_we, map_valid, map_level, reg_req, reg_we;
  logic [15:0] ev_id, map_idx;
  logic [1:0]  map_vint;
  logic [5:0]  map_bit;
  logic [14:0] reg_addr;
  logic [63:0] reg_wdata, reg_rdata;
  logic [3:0]  irq_out;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [63:0] m_en [NV];
  logic [63:0] m_st [NV];
  logic [63:0] m_lv [NV];
  bit          r_valid [MD];
  bit          r_level [MD];
  int          r_vint  [MD];
  int          r_bit   [MD];
  logic [63:0] last_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  vint_aggregator dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_id(ev_id), .ev_down(ev_down),
    .map_we(map_we), .map_idx(map_idx), .map_valid(map_valid),
    .map_level(map_level), .map_vint(map_vint), .map_bit(map_bit),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  function automatic logic [14:0] adr(int w, int o);
    return {w[2:0], o[11:0]};
  endfunction

  function automatic logic [63:0] model_read(logic [14:0] a);
    int w = int'(a[14:12]);
    int o = int'(a[11:0]);
    if (w >= NV) return 64'h0;
    case (o)
      'h000, 'h008: return m_en[w];
      'h018:        return m_st[w];
      'h020:        return m_st[w] & m_en[w];
      default:      return 64'h0;
    endcase
  endfunction

  function automatic string read_tag(logic [14:0] a);
    int w = int'(a[14:12]);
    int o = int'(a[11:0]);
    if (w >= NV) return "R11";
    case (o)
      'h000, 'h008: return "R2";
      'h018:        return "R4";
      'h020:        return "R5";
      default:      return "R11";
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ev_valid = 0; ev_id = '0; ev_down = 0;
    map_we = 0; map_idx = '0; map_valid = 0; map_level = 0; map_vint = '0; map_bit = '0;
    reg_req = 0; reg_we = 0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic model_update();
    logic [63:0] ack [NV];
    logic [63:0] arr [NV];
    logic [63:0] arl [NV];
    logic [63:0] dn  [NV];
    int w = int'(reg_addr[14:12]);
    int o = int'(reg_addr[11:0]);
    for (int v = 0; v < NV; v++) begin ack[v] = 0; arr[v] = 0; arl[v] = 0; dn[v] = 0; end
    if (reg_req && reg_we && w < NV) begin
      if (o == 'h000) m_en[w] = m_en[w] | reg_wdata;
      if (o == 'h008) m_en[w] = m_en[w] & ~reg_wdata;
      if (o == 'h018) ack[w] = reg_wdata;
    end
    if (ev_valid && int'(ev_id) < MD && r_valid[ev_id]) begin
      int tv = r_vint[ev_id];
      logic [63:0] b = 64'h1 << r_bit[ev_id];
      if (tv < NV) begin
        if (ev_down) dn[tv] = b;
        else begin
          arr[tv] = b;
          if (r_level[ev_id]) arl[tv] = b;
        end
      end
    end
    for (int v = 0; v < NV; v++) begin
      m_st[v] = (m_st[v] & ~(ack[v] & ~m_lv[v]) & ~dn[v]) | arr[v];
      m_lv[v] = (m_lv[v] & ~dn[v] & ~(arr[v] & ~arl[v])) | arl[v];
    end
    if (map_we && int'(map_idx) < MD) begin
      r_valid[map_idx] = map_valid;
      r_level[map_idx] = map_level;
      r_vint[map_idx]  = int'(map_vint);
      r_bit[map_idx]   = int'(map_bit);
    end
  endtask

  // Called at a negedge with inputs already driven; returns at the next negedge.
  task automatic step(string tag);
    bit          is_rd = reg_req && !reg_we;
    logic [63:0] exp_rd;
    string       rt;
    @(posedge clk);
    if (is_rd) begin
      exp_rd = model_read(reg_addr);
      rt = (tag != "") ? tag : read_tag(reg_addr);
    end else begin
      exp_rd = last_rd;
      rt = (tag != "") ? tag : "R12";
    end
    model_update();
    @(negedge clk);
    chk(rt, reg_rdata, exp_rd);
    last_rd = exp_rd;
    for (int v = 0; v < NV; v++)
      chk((tag != "") ? tag : "R6", {63'h0, irq_out[v]}, {63'h0, |(m_en[v] & m_st[v])});
    idle_inputs();
  endtask

  task automatic wr(int w, int o, logic [63:0] d, string tag);
    reg_req = 1; reg_we = 1; reg_addr = adr(w, o); reg_wdata = d;
    step(tag);
  endtask

  task automatic rd(int w, int o, string tag);
    reg_req = 1; reg_we = 0; reg_addr = adr(w, o);
    step(tag);
  endtask

  task automatic evt(int id, bit down, string tag);
    ev_valid = 1; ev_id = 16'(id); ev_down = down;
    step(tag);
  endtask

  task automatic route(int idx, bit vld, bit lvl, int vi, int bp);
    map_we = 1; map_idx = 16'(idx); map_valid = vld; map_level = lvl;
    map_vint = 2'(vi); map_bit = 6'(bp);
    step("R7");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL R12 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int v = 0; v < NV; v++) begin m_en[v] = 0; m_st[v] = 0; m_lv[v] = 0; end
    for (int i = 0; i < MD; i++) begin r_valid[i] = 0; r_level[i] = 0; r_vint[i] = 0; r_bit[i] = 0; end
    last_rd = 0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1", {60'h0, irq_out}, 64'h0);
    chk("R1", reg_rdata, 64'h0);
    rd(0, 'h000, "R1");
    rd(3, 'h018, "R1");
    evt(5, 0, "R1");                       // no valid route after reset
    rd(0, 'h018, "R1");

    // R7: routes
    route(5, 1, 0, 1, 7);
    route(9, 1, 1, 2, 63);
    route(3, 0, 0, 0, 0);
    route(70, 1, 0, 0, 1);                  // index beyond depth: ignored

    // R4 / R6: arrival while masked
    evt(5, 0, "R4");
    rd(1, 'h018, "R4");
    rd(1, 'h020, "R5");
    // R2: enable bit 7
    wr(1, 'h000, 64'h80, "R2");
    chk("R6", {63'h0, irq_out[1]}, 64'h1);
    rd(1, 'h008, "R2");
    // R5: masked status is read-only
    wr(1, 'h020, '1, "R5");
    rd(1, 'h000, "R5");
    // R9: ack and arrival collide
    reg_req = 1; reg_we = 1; reg_addr = adr(1, 'h018); reg_wdata = 64'h80;
    ev_valid = 1; ev_id = 16'd5;
    step("R9");
    rd(1, 'h018, "R9");
    // R8: plain ack clears
    wr(1, 'h018, 64'h80, "R8");
    rd(1, 'h018, "R8");
    chk("R8", {63'h0, irq_out[1]}, 64'h0);
    // R7: dropped events
    evt(3, 0, "R7");
    evt(100, 0, "R7");
    rd(0, 'h018, "R7");
    evt(70, 0, "R7");
    rd(0, 'h018, "R7");
    // R10: level route
    evt(9, 0, "R10");
    wr(2, 'h000, 64'h8000_0000_0000_0000, "R10");
    wr(2, 'h018, '1, "R10");
    rd(2, 'h018, "R10");
    chk("R10", {63'h0, irq_out[2]}, 64'h1);
    evt(9, 1, "R10");
    rd(2, 'h018, "R10");
    // R3: clear enable
    wr(1, 'h000, 64'hF0F0, "R3");
    wr(1, 'h008, 64'h00F0, "R3");
    rd(1, 'h000, "R3");
    // R11: unimplemented windows and offsets
    wr(5, 'h000, '1, "R11");
    wr(0, 'h010, '1, "R11");
    wr(0, 'h004, '1, "R11");
    rd(5, 'h000, "R11");
    rd(0, 'h010, "R11");
    rd(0, 'h000, "R11");
    rd(2, 'h000, "R11");
    // R12: idle cycles hold the read data
    rd(1, 'h000, "R12");
    repeat (3) step("R12");

    // random phase
    for (int n = 0; n < 1500; n++) begin
      int op = $urandom_range(0, 9);
      int ofs_pick = $urandom_range(0, 6);
      int ofs_tab [7] = '{'h000, 'h008, 'h018, 'h020, 'h010, 'h01c, 'h028};
      if (op < 6) begin
        reg_req = 1;
        reg_we = (op < 3);
        reg_addr = adr($urandom_range(0, 7) % ((op == 5) ? 8 : 4), ofs_tab[ofs_pick]);
        reg_wdata = {$urandom, $urandom};
        if ($urandom_range(0, 3) != 0) reg_wdata = reg_wdata & {$urandom, $urandom};
      end
      if ($urandom_range(0, 1) == 1) begin
        ev_valid = 1;
        ev_id = 16'($urandom_range(0, 79));
        ev_down = ($urandom_range(0, 3) == 0);
      end
      if ($urandom_range(0, 7) == 0) begin
        map_we = 1;
        map_idx = 16'($urandom_range(0, 70));
        map_valid = ($urandom_range(0, 4) != 0);
        map_level = ($urandom_range(0, 2) == 0);
        map_vint = 2'($urandom_range(0, 3));
        map_bit = 6'($urandom_range(0, 63));
      end
      step("");
    end
    for (int v = 0; v < NV; v++) begin
      rd(v, 'h000, "R2");
      rd(v, 'h018, "R4");
      rd(v, 'h020, "R5");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule